// File: doc/BRIEF.md
# Grouped Interrupt Priority Signaller

This block serves one processor interface of an interrupt controller. Every clock it looks at a parameterised set of interrupt sources, each with a pending flag, an enable flag, an 8-bit priority and a group bit. It keeps only the sources that are both pending and enabled and picks the most urgent one. A numerically smaller priority is more urgent, and the lowest source number wins a tie.

The winner is then tested against the interface's priority mask and running priority. The two group-enable fields (one for the distributor, one for the processor interface) and a fast-interrupt enable decide whether the winner drives the normal interrupt line, the fast interrupt line, or neither. The number of the winning source is reported as the current-pending ID. When nothing passes the mask, the reserved ID 1023 is reported instead.

All inputs are captured in a register stage and both output lines are registered. A change at the inputs therefore reaches the outputs at the second rising edge after it is applied.

Top module: `grp_irq_signaller`

## Requirements
- R1: When the distributor group-enable field is 2'b00, or the processor group-enable field is 2'b00, both `irq_o` and `fiq_o` are low.
- R2: Only sources with pending=1 and enable=1 compete. The smallest priority value wins, and among equal priorities the lowest source number wins. Source i's priority is bits [8i+7:8i] of `src_prio_i`.
- R3: `cur_pend_id_o` carries the winner's number when the winner's priority is strictly less than `prio_mask_i`. Otherwise, including when no source competes, it carries 1023. The group enables do not affect it.
- R4: An output line can be high only when the winner's priority is strictly less than both `prio_mask_i` and `run_prio_i`.
- R5: The winner's group bit g (0 or 1) selects bit g of both group-enable fields. Both bits must be 1 for any line to be raised. A less urgent source of another group is never used in its place.
- R6: A raised winner of group 0 drives `fiq_o` when `cpu_fiq_en_i` is 1. In every other raised case it drives `irq_o`. The two lines are never high together.
- R7: An input value present at rising edge k determines the outputs seen after rising edge k+1.
- R8: During synchronous reset (`rst_n` low at an edge) the outputs become `irq_o`=0, `fiq_o`=0 and `cur_pend_id_o`=1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_pend_i | input | NUM_SRC | Pending flag per source |
| src_en_i | input | NUM_SRC | Enable flag per source |
| src_grp_i | input | NUM_SRC | Group bit per source (0 or 1) |
| src_prio_i | input | 8*NUM_SRC | Priority per source, source i at bits [8i+7:8i] |
| dist_grp_en_i | input | 2 | Distributor enables, bit g for group g |
| cpu_grp_en_i | input | 2 | Processor-interface enables, bit g for group g |
| cpu_fiq_en_i | input | 1 | Route group-0 winners to the fast line |
| prio_mask_i | input | 8 | Priority mask |
| run_prio_i | input | 8 | Running priority |
| irq_o | output | 1 | Normal interrupt level |
| fiq_o | output | 1 | Fast interrupt level |
| cur_pend_id_o | output | 10 | Current-pending source number, 1023 when none |

## Verification
On every cycle the assertions check the following relations against the registered control state:
- both lines are low after a global disable, a zero running priority, or a cleared fast enable on the fast line;
- the two lines are mutually exclusive;
- the spurious ID never coincides with a raised line;
- a zero mask forces the spurious ID;
- the ID stays in range.

Only the bench's scenarios can show the rest: that the right source wins, including ties and disabled sources; that the strict boundaries at the mask and running priority hold; that a disabled winning group blocks the output rather than passing to another source; and the exact two-edge latency. The bench covers these with directed cases and a long randomized run checked against its reference model.

// File: rtl/gis_pkg.sv
// Shared types for the grouped interrupt priority signaller.
// Assumes 8-bit priorities and a 10-bit interrupt ID space.
package gis_pkg;
    localparam int PRIO_W = 8;
    localparam int ID_W   = 10;
    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

    // One competing source as it travels through the selection tree.
    typedef struct packed {
        logic              vld;
        logic              grp;
        logic [PRIO_W-1:0] prio;
        logic [ID_W-1:0]   id;
    } cand_t;

    // Processor-interface and distributor control state.
    typedef struct packed {
        logic [1:0]        dist_en;
        logic [1:0]        cpu_en;
        logic              fiq_en;
        logic [PRIO_W-1:0] mask;
        logic [PRIO_W-1:0] run;
    } ctl_t;
endpackage

// File: rtl/gis_in_stage.sv
// Input capture stage: registers all source and control inputs so that
// the selection logic always works from values stable for a full cycle.
// Assumes a synchronous active-low reset; reset clears every field.
module gis_in_stage
    import gis_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        pend_i,
    input  logic [NUM_SRC-1:0]        en_i,
    input  logic [NUM_SRC-1:0]        grp_i,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
    input  ctl_t                      ctl_i,
    output logic [NUM_SRC-1:0]        pend_q,
    output logic [NUM_SRC-1:0]        en_q,
    output logic [NUM_SRC-1:0]        grp_q,
    output logic [NUM_SRC*PRIO_W-1:0] prio_q,
    output ctl_t                      ctl_q
);
    // Capture every input on each rising edge; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            en_q   <= '0;
            grp_q  <= '0;
            prio_q <= '0;
            ctl_q  <= '0;
        end else begin
            pend_q <= pend_i;
            en_q   <= en_i;
            grp_q  <= grp_i;
            prio_q <= prio_i;
            ctl_q  <= ctl_i;
        end
    end
endmodule

// File: rtl/gis_pick.sv
// Selection tree: a balanced tournament that finds the most urgent
// pending-and-enabled source. Smaller priority wins; on equal priority
// the left (lower-numbered) branch wins. Pads to a power of two with
// invalid leaves. Assumes NUM_SRC <= 1023 so that real IDs never
// collide with the spurious ID.
module gis_pick
    import gis_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic [NUM_SRC-1:0]        pend_i,
    input  logic [NUM_SRC-1:0]        en_i,
    input  logic [NUM_SRC-1:0]        grp_i,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
    output cand_t                     best_o
);
    localparam int LEAVES = (NUM_SRC < 2) ? 2 : (1 << $clog2(NUM_SRC));
    localparam int LVLS   = $clog2(LEAVES);

    genvar lv, k;
    for (lv = 0; lv <= LVLS; lv++) begin : g_lvl
        localparam int W = LEAVES >> lv;
        cand_t node [W];
        if (lv == 0) begin : g_leaf
            for (k = 0; k < W; k++) begin : g_k
                if (k < NUM_SRC) begin : g_real
                    // Leaf: a source competes only if pending and enabled.
                    assign node[k] = '{vld:  pend_i[k] & en_i[k],
                                       grp:  grp_i[k],
                                       prio: prio_i[k*PRIO_W +: PRIO_W],
                                       id:   ID_W'(k)};
                end else begin : g_pad
                    assign node[k] = '0;
                end
            end
        end else begin : g_merge
            for (k = 0; k < W; k++) begin : g_k
                cand_t lo, hi;
                assign lo = g_lvl[lv-1].node[2*k];
                assign hi = g_lvl[lv-1].node[2*k+1];
                // Merge: lower branch keeps ties, invalid loses.
                assign node[k] = (lo.vld && (!hi.vld || lo.prio <= hi.prio)) ? lo : hi;
            end
        end
    end

    assign best_o = g_lvl[LVLS].node[0];
endmodule

// File: rtl/gis_route.sv
// Routing decision: applies the mask and running-priority thresholds,
// the per-group enables and the fast-interrupt enable to the winner.
// Purely combinational; the top registers its results.
module gis_route
    import gis_pkg::*;
(
    input  cand_t           best_i,
    input  ctl_t            ctl_i,
    output logic            irq_n,
    output logic            fiq_n,
    output logic [ID_W-1:0] id_n
);
    logic any_grp;
    logic pass_mask;
    logic pass_run;
    logic grp_ok;
    logic fire;

    // Threshold and enable evaluation for the single winner.
    always_comb begin
        any_grp   = (|ctl_i.dist_en) && (|ctl_i.cpu_en);
        pass_mask = best_i.vld && (best_i.prio < ctl_i.mask);
        pass_run  = pass_mask && (best_i.prio < ctl_i.run);
        grp_ok    = ctl_i.dist_en[best_i.grp] && ctl_i.cpu_en[best_i.grp];
        fire      = any_grp && pass_run && grp_ok;
        fiq_n     = fire && !best_i.grp && ctl_i.fiq_en;
        irq_n     = fire && !fiq_n;
        id_n      = pass_mask ? best_i.id : SPURIOUS_ID;
    end
endmodule

// File: rtl/grp_irq_signaller.sv
// Grouped interrupt priority signaller for one processor interface.
// Inputs are registered, the winner is chosen by a tournament tree, the
// routing decision is registered onto irq_o / fiq_o / cur_pend_id_o.
// Latency: input at edge k appears on outputs after edge k+1.
module grp_irq_signaller
    import gis_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        src_pend_i,
    input  logic [NUM_SRC-1:0]        src_en_i,
    input  logic [NUM_SRC-1:0]        src_grp_i,
    input  logic [NUM_SRC*PRIO_W-1:0] src_prio_i,
    input  logic [1:0]                dist_grp_en_i,
    input  logic [1:0]                cpu_grp_en_i,
    input  logic                      cpu_fiq_en_i,
    input  logic [PRIO_W-1:0]         prio_mask_i,
    input  logic [PRIO_W-1:0]         run_prio_i,
    output logic                      irq_o,
    output logic                      fiq_o,
    output logic [ID_W-1:0]           cur_pend_id_o
);
    ctl_t                      ctl_d;
    ctl_t                      ctl_q;
    logic [NUM_SRC-1:0]        pend_q;
    logic [NUM_SRC-1:0]        en_q;
    logic [NUM_SRC-1:0]        grp_q;
    logic [NUM_SRC*PRIO_W-1:0] prio_q;
    cand_t                     best;
    logic                      irq_n;
    logic                      fiq_n;
    logic [ID_W-1:0]           id_n;

    // Gather the control inputs into one record.
    always_comb begin
        ctl_d.dist_en = dist_grp_en_i;
        ctl_d.cpu_en  = cpu_grp_en_i;
        ctl_d.fiq_en  = cpu_fiq_en_i;
        ctl_d.mask    = prio_mask_i;
        ctl_d.run     = run_prio_i;
    end

    gis_in_stage #(.NUM_SRC(NUM_SRC)) u_in (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (src_pend_i),
        .en_i   (src_en_i),
        .grp_i  (src_grp_i),
        .prio_i (src_prio_i),
        .ctl_i  (ctl_d),
        .pend_q (pend_q),
        .en_q   (en_q),
        .grp_q  (grp_q),
        .prio_q (prio_q),
        .ctl_q  (ctl_q)
    );

    gis_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .pend_i (pend_q),
        .en_i   (en_q),
        .grp_i  (grp_q),
        .prio_i (prio_q),
        .best_o (best)
    );

    gis_route u_route (
        .best_i (best),
        .ctl_i  (ctl_q),
        .irq_n  (irq_n),
        .fiq_n  (fiq_n),
        .id_n   (id_n)
    );

    // Output registers: levels and current-pending ID.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o         <= 1'b0;
            fiq_o         <= 1'b0;
            cur_pend_id_o <= SPURIOUS_ID;
        end else begin
            irq_o         <= irq_n;
            fiq_o         <= fiq_n;
            cur_pend_id_o <= id_n;
        end
    end
endmodule

// File: rtl/gis_checks.sv
// Property checker for grp_irq_signaller, bound to every instance.
// Relates the registered control state to the registered outputs.
module gis_checks
    import gis_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_o,
    input logic              fiq_o,
    input logic [ID_W-1:0]   cur_id,
    input logic [1:0]        q_dist_en,
    input logic [1:0]        q_cpu_en,
    input logic              q_fiq_en,
    input logic [PRIO_W-1:0] q_mask,
    input logic [PRIO_W-1:0] q_run
);
    // R1: global disable silences both lines on the next edge.
    a_r1_global_off: assert property (@(posedge clk) disable iff (!rst_n)
        (q_dist_en == 2'b00 || q_cpu_en == 2'b00) |=> (!irq_o && !fiq_o));

    // R4: nothing is strictly below a running priority of zero.
    a_r4_run_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (q_run == '0) |=> (!irq_o && !fiq_o));

    // R3: nothing is strictly below a mask of zero.
    a_r3_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (q_mask == '0) |=> (cur_id == SPURIOUS_ID));

    // R3: a raised line always comes with a real ID in range.
    a_r3_id_with_line: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || fiq_o) |-> (cur_id != SPURIOUS_ID && cur_id < ID_W'(NUM_SRC)));

    // R3: the ID is either spurious or a real source number.
    a_r3_id_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_id == SPURIOUS_ID) || (cur_id < ID_W'(NUM_SRC)));

    // R6: the lines are mutually exclusive.
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_o, fiq_o}));

    // R6: the fast line needs the fast-interrupt enable.
    a_r6_fiq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        !q_fiq_en |=> !fiq_o);
endmodule

bind grp_irq_signaller gis_checks #(.NUM_SRC(NUM_SRC)) u_gis_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o),
    .cur_id    (cur_pend_id_o),
    .q_dist_en (ctl_q.dist_en),
    .q_cpu_en  (ctl_q.cpu_en),
    .q_fiq_en  (ctl_q.fiq_en),
    .q_mask    (ctl_q.mask),
    .q_run     (ctl_q.run)
);

// File: tb/tb_grp_irq_signaller.sv
`timescale 1ns/1ps
// Bench: behavioural reference model fed with the same stimulus, its
// predictions delayed by a queue and compared at every falling edge.
module tb_grp_irq_signaller;
    localparam int N = 32;

    typedef struct packed {
        logic       irq;
        logic       fiq;
        logic [9:0] id;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [N-1:0]     pend, en, grp;
    logic [N*8-1:0]   prio;
    logic [1:0]       dist_en, cpu_en;
    logic             fiq_en;
    logic [7:0]       mask, run;
    logic             irq_o, fiq_o;
    logic [9:0]       cur_id;

    int     n_cmp  = 0;
    int     n_bad  = 0;
    bit     done   = 1'b0;
    exp_t   exp_q[$];
    string  tag_q[$];

    always #10 clk = ~clk;

    grp_irq_signaller #(.NUM_SRC(N)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .src_pend_i    (pend),
        .src_en_i      (en),
        .src_grp_i     (grp),
        .src_prio_i    (prio),
        .dist_grp_en_i (dist_en),
        .cpu_grp_en_i  (cpu_en),
        .cpu_fiq_en_i  (fiq_en),
        .prio_mask_i   (mask),
        .run_prio_i    (run),
        .irq_o         (irq_o),
        .fiq_o         (fiq_o),
        .cur_pend_id_o (cur_id)
    );

    // Reference model written from the requirements.
    function automatic exp_t model();
        exp_t r;
        int best = 256;
        int bid  = -1;
        int g;
        r = '{irq: 1'b0, fiq: 1'b0, id: 10'd1023};
        for (int i = 0; i < N; i++) begin
            if (pend[i] && en[i] && int'(prio[i*8 +: 8]) < best) begin
                best = int'(prio[i*8 +: 8]);
                bid  = i;
            end
        end
        if (best < int'(mask)) r.id = 10'(bid);
        if (dist_en == 2'b00 || cpu_en == 2'b00) return r;
        if (best < int'(mask) && best < int'(run)) begin
            g = int'(grp[bid]);
            if (dist_en[g] && cpu_en[g]) begin
                if (g == 0 && fiq_en) r.fiq = 1'b1;
                else                  r.irq = 1'b1;
            end
        end
        return r;
    endfunction

    task automatic cmp1(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Wait for a falling edge and compare against the prediction made
    // two falling edges earlier.
    task automatic tick();
        exp_t  e;
        string t;
        @(negedge clk);
        if (exp_q.size() >= 2) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            cmp1(t, "irq", int'(irq_o), int'(e.irq));
            cmp1(t, "fiq", int'(fiq_o), int'(e.fiq));
            cmp1(t, "id",  int'(cur_id), int'(e.id));
        end
    endtask

    task automatic push(string tag);
        exp_q.push_back(model());
        tag_q.push_back(tag);
    endtask

    task automatic clear_src();
        pend = '0; en = '0; grp = '0; prio = '1;
    endtask

    task automatic set_src(int i, logic p, logic e, logic g, logic [7:0] pr);
        pend[i] = p; en[i] = e; grp[i] = g; prio[i*8 +: 8] = pr;
    endtask

    task automatic open_ctl();
        dist_en = 2'b11; cpu_en = 2'b11; fiq_en = 1'b0; mask = 8'hFF; run = 8'hFF;
    endtask

    // Hold the current stimulus for a few cycles, with its own tag.
    task automatic hold(string tag, int n);
        for (int c = 0; c < n; c++) begin
            tick();
            push(tag);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        clear_src();
        dist_en = 2'b00; cpu_en = 2'b00; fiq_en = 1'b0; mask = '0; run = '0;
        // R8: reset values after edges with reset low, even with active inputs.
        set_src(4, 1'b1, 1'b1, 1'b0, 8'h01);
        open_ctl();
        fiq_en = 1'b1;
        repeat (3) @(negedge clk);
        cmp1("R8", "irq", int'(irq_o), 0);
        cmp1("R8", "fiq", int'(fiq_o), 0);
        cmp1("R8", "id",  int'(cur_id), 1023);

        // R7: release reset and pulse one source for one cycle only.
        tick();
        rst_n = 1'b1;
        clear_src();
        open_ctl();
        push("R7 idle");
        tick();
        set_src(7, 1'b1, 1'b1, 1'b1, 8'h20);
        push("R7 pulse");
        tick();
        clear_src();
        push("R7 after pulse");
        hold("R7 idle", 3);

        // R2: tie between ids 5 and 9 goes to 5.
        tick();
        open_ctl();
        clear_src();
        set_src(9, 1'b1, 1'b1, 1'b1, 8'h40);
        set_src(5, 1'b1, 1'b1, 1'b1, 8'h40);
        push("R2 tie");
        hold("R2 tie", 2);

        // R2: a more urgent source that is not enabled does not compete.
        tick();
        set_src(3, 1'b1, 1'b0, 1'b1, 8'h10);
        set_src(2, 1'b0, 1'b1, 1'b1, 8'h08);
        push("R2 not eligible");
        hold("R2 not eligible", 2);

        // R3: priority equal to mask is not enough.
        tick();
        clear_src();
        set_src(12, 1'b1, 1'b1, 1'b1, 8'h80);
        mask = 8'h80;
        push("R3 mask equal");
        hold("R3 mask equal", 2);
        tick();
        mask = 8'h81;
        push("R3 mask above");
        hold("R3 mask above", 2);

        // R4: priority equal to running priority keeps the lines low.
        tick();
        run = 8'h80;
        push("R4 run equal");
        hold("R4 run equal", 2);
        tick();
        run = 8'h81;
        push("R4 run above");
        hold("R4 run above", 2);

        // R5: winner in group 1 with group 1 disabled at the interface;
        // a group-0 source of lower urgency must not take its place.
        tick();
        open_ctl();
        clear_src();
        set_src(20, 1'b1, 1'b1, 1'b1, 8'h10);
        set_src(21, 1'b1, 1'b1, 1'b0, 8'h30);
        cpu_en = 2'b01;
        push("R5 group blocked");
        hold("R5 group blocked", 2);
        tick();
        cpu_en  = 2'b11;
        dist_en = 2'b01;
        push("R5 dist group blocked");
        hold("R5 dist group blocked", 2);

        // R6: group-0 winner with and without the fast enable.
        tick();
        open_ctl();
        clear_src();
        set_src(30, 1'b1, 1'b1, 1'b0, 8'h05);
        fiq_en = 1'b1;
        push("R6 fast");
        hold("R6 fast", 2);
        tick();
        fiq_en = 1'b0;
        push("R6 normal");
        hold("R6 normal", 2);
        tick();
        fiq_en = 1'b1;
        grp[30] = 1'b1;
        push("R6 group1 fast en");
        hold("R6 group1 fast en", 2);

        // R1: global disables at either side.
        tick();
        dist_en = 2'b00;
        push("R1 dist off");
        hold("R1 dist off", 2);
        tick();
        dist_en = 2'b11;
        cpu_en  = 2'b00;
        push("R1 cpu off");
        hold("R1 cpu off", 2);

        // R2 R3 R4 R5 R6: randomized stimulus with frequent ties.
        for (int c = 0; c < 3000; c++) begin
            tick();
            pend = N'($urandom());
            en   = N'($urandom()) | N'($urandom());
            grp  = N'($urandom());
            for (int i = 0; i < N; i++) prio[i*8 +: 8] = 8'(($urandom() % 16) * 16);
            dist_en = 2'($urandom());
            cpu_en  = 2'($urandom());
            if ($urandom() % 4 != 0) begin dist_en = 2'b11; cpu_en = 2'($urandom() | 1); end
            fiq_en = 1'($urandom());
            mask   = 8'($urandom());
            run    = 8'($urandom());
            push("R2 R3 R4 R5 R6 random");
        end
        hold("R7 drain", 3);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule